// File: doc/BRIEF.md
# x86 Effective Address Generator

This block turns the addressing bytes of a 32-bit x86 instruction into an operand location. It takes the ModR/M byte, the SIB byte, up to four displacement bytes and the opcode's direction bit. From these it decides one of two outcomes. Either the R/M operand is a register, or it is a memory operand whose effective address must be computed. It also reports how many SIB and displacement bytes the instruction uses, so that the fetch logic can step past them.

The block reads register values through two combinational read ports. It drives a base selector and an index selector, and the register file returns the two values in the same cycle. Each request arrives as a one-cycle `inValid` pulse. The block registers the whole decode and presents it one clock later with `outValid` high. The registered results then hold until the next request.

Top module: `x86EaGen`

## Requirements
- R1: While reset is asserted and after it is released, with no request made, `outValid`, `effAddr`, `regMode`, `regField`, `regIsDst`, `rmField`, `sibLen` and `dispLen` are all zero.
- R2: `outValid` is high exactly in the cycle after a cycle with `inValid` high. Without `inValid` all result outputs hold their values, even when the inputs change.
- R3: MOD (ModR/M bits 7:6) equal to 3 gives `regMode`=1, `effAddr`=0, `sibLen`=0 and `dispLen`=0. In every other case `regMode` is 0.
- R4: MOD=0 with R/M (bits 2:0) other than 4 or 5 gives `effAddr` = register[R/M] and `dispLen`=0.
- R5: MOD=0 with R/M=5 gives `effAddr` = the 32-bit displacement and `dispLen`=4, with no register term.
- R6: MOD=1 adds the sign-extended displacement byte `disp[7:0]` to the base, with `dispLen`=1.
- R7: MOD=2 adds the 32-bit displacement to the base, with `dispLen`=4. The displacement is little-endian: the first fetched byte is in `disp[7:0]`.
- R8: R/M=4 with MOD other than 3 sets `sibLen`=1. The address is then register[BASE] + (register[INDEX] << SCALE) + displacement, where SIB holds SCALE in bits 7:6, INDEX in bits 5:3 and BASE in bits 2:0.
- R9: An SIB INDEX of 4 contributes no index term, whatever the SCALE.
- R10: An SIB BASE of 5 under MOD=0 drops the base term and adds a 32-bit displacement (`dispLen`=4).
- R11: `regField` equals ModR/M bits 5:3, `rmField` equals bits 2:0, and `regIsDst` equals the direction bit. A value of 1 means REG is the destination and R/M is the source.
- R12: The address sum wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Request strobe; inputs are sampled on this cycle |
| dirBit | input | 1 | Opcode direction bit |
| modrm | input | 8 | ModR/M byte |
| sib | input | 8 | SIB byte (ignored unless used) |
| disp | input | 32 | Displacement bytes, first fetched byte in bits 7:0 |
| baseSel | output | 3 | Register number for the base read port |
| baseVal | input | 32 | Value returned for baseSel |
| indexSel | output | 3 | Register number for the index read port |
| indexVal | input | 32 | Value returned for indexSel |
| outValid | output | 1 | Result valid, one cycle after inValid |
| effAddr | output | 32 | Effective address (zero in register mode) |
| regMode | output | 1 | R/M operand is a register |
| regField | output | 3 | REG field of ModR/M |
| regIsDst | output | 1 | REG is the destination operand |
| rmField | output | 3 | R/M field of ModR/M |
| sibLen | output | 1 | Number of SIB bytes used |
| dispLen | output | 3 | Number of displacement bytes used (0, 1 or 4) |

## Verification
There is exactly one register stage between a request and its result. The bench applies each request on a falling edge with `inValid` high. It drops `inValid` on the next falling edge and compares every output there, after the single rising edge that loads the results. The register read ports answer combinationally within the request cycle, so the model uses the register values for that same cycle. A separate sequence changes the inputs while `inValid` is low. It then checks, one and several cycles later, that the results have not moved and that `outValid` is low.

// File: rtl/x86EaGenPkg.sv
package x86EaGenPkg;

  typedef enum logic [1:0] {
    DISP_NONE  = 2'd0,
    DISP_BYTE  = 2'd1,
    DISP_DWORD = 2'd2
  } dispKind_e;

  typedef struct packed {
    logic      load;
    logic      regMode;
    logic      sibUsed;
    logic      useBase;
    logic      useIndex;
    logic [1:0] scale;
    dispKind_e dispKind;
  } ctrlStrobe_t;

endpackage

// File: rtl/x86EaGenCtrl.sv
module x86EaGenCtrl
  import x86EaGenPkg::*;
#(
  parameter int REG_SEL_W = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic [7:0]           modrm,
  input  logic [7:0]           sib,
  output logic [REG_SEL_W-1:0] baseSel,
  output logic [REG_SEL_W-1:0] indexSel,
  output ctrlStrobe_t          strobe,
  output logic                 outValid
);

  localparam logic [2:0] RM_SIB    = 3'd4;
  localparam logic [2:0] RM_DIRECT = 3'd5;
  localparam logic [2:0] NO_INDEX  = 3'd4;

  logic [1:0] modF;
  logic [2:0] rmF;
  logic [2:0] sibBase;
  logic [2:0] sibIndex;
  logic       regModeC;
  logic       sibUsedC;
  logic       noBaseC;

  assign modF     = modrm[7:6];
  assign rmF      = modrm[2:0];
  assign sibBase  = sib[2:0];
  assign sibIndex = sib[5:3];

  assign regModeC = (modF == 2'd3);
  assign sibUsedC = !regModeC && (rmF == RM_SIB);
  assign noBaseC  = (modF == 2'd0) &&
                    (sibUsedC ? (sibBase == RM_DIRECT) : (rmF == RM_DIRECT));

  assign baseSel  = REG_SEL_W'(sibUsedC ? sibBase : rmF);
  assign indexSel = REG_SEL_W'(sibIndex);

  always_comb begin
    strobe          = '0;
    strobe.load     = inValid;
    strobe.regMode  = regModeC;
    strobe.sibUsed  = sibUsedC;
    strobe.useBase  = !regModeC && !noBaseC;
    strobe.useIndex = sibUsedC && (sibIndex != NO_INDEX);
    strobe.scale    = sib[7:6];
    unique case (modF)
      2'd0:    strobe.dispKind = noBaseC ? DISP_DWORD : DISP_NONE;
      2'd1:    strobe.dispKind = DISP_BYTE;
      2'd2:    strobe.dispKind = DISP_DWORD;
      default: strobe.dispKind = DISP_NONE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

endmodule

// File: rtl/x86EaGenDatapath.sv
module x86EaGenDatapath
  import x86EaGenPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic              dirBit,
  input  logic [7:0]        modrm,
  input  logic [DATA_W-1:0] disp,
  input  logic [DATA_W-1:0] baseVal,
  input  logic [DATA_W-1:0] indexVal,
  output logic [DATA_W-1:0] effAddr,
  output logic              regMode,
  output logic [2:0]        regField,
  output logic              regIsDst,
  output logic [2:0]        rmField,
  output logic              sibLen,
  output logic [2:0]        dispLen
);

  localparam int SEXT_W = DATA_W - 8;

  logic [DATA_W-1:0] baseTerm;
  logic [DATA_W-1:0] indexTerm;
  logic [DATA_W-1:0] dispTerm;
  logic [DATA_W-1:0] sumC;
  logic [2:0]        dispLenC;

  assign baseTerm  = strobe.useBase  ? baseVal : '0;
  assign indexTerm = strobe.useIndex ? (indexVal << strobe.scale) : '0;

  always_comb begin
    unique case (strobe.dispKind)
      DISP_BYTE:  begin dispTerm = {{SEXT_W{disp[7]}}, disp[7:0]}; dispLenC = 3'd1; end
      DISP_DWORD: begin dispTerm = disp;                           dispLenC = 3'd4; end
      default:    begin dispTerm = '0;                             dispLenC = 3'd0; end
    endcase
  end

  assign sumC = baseTerm + indexTerm + dispTerm;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      effAddr  <= '0;
      regMode  <= 1'b0;
      regField <= '0;
      regIsDst <= 1'b0;
      rmField  <= '0;
      sibLen   <= 1'b0;
      dispLen  <= '0;
    end else if (strobe.load) begin
      effAddr  <= strobe.regMode ? '0 : sumC;
      regMode  <= strobe.regMode;
      regField <= modrm[5:3];
      regIsDst <= dirBit;
      rmField  <= modrm[2:0];
      sibLen   <= strobe.sibUsed;
      dispLen  <= dispLenC;
    end
  end

endmodule

// File: rtl/x86EaGen.sv
module x86EaGen
  import x86EaGenPkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int REG_SEL_W = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic                 dirBit,
  input  logic [7:0]           modrm,
  input  logic [7:0]           sib,
  input  logic [DATA_W-1:0]    disp,
  output logic [REG_SEL_W-1:0] baseSel,
  input  logic [DATA_W-1:0]    baseVal,
  output logic [REG_SEL_W-1:0] indexSel,
  input  logic [DATA_W-1:0]    indexVal,
  output logic                 outValid,
  output logic [DATA_W-1:0]    effAddr,
  output logic                 regMode,
  output logic [2:0]           regField,
  output logic                 regIsDst,
  output logic [2:0]           rmField,
  output logic                 sibLen,
  output logic [2:0]           dispLen
);

  ctrlStrobe_t strobe;

  x86EaGenCtrl #(.REG_SEL_W(REG_SEL_W)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .modrm    (modrm),
    .sib      (sib),
    .baseSel  (baseSel),
    .indexSel (indexSel),
    .strobe   (strobe),
    .outValid (outValid)
  );

  x86EaGenDatapath #(.DATA_W(DATA_W)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .dirBit   (dirBit),
    .modrm    (modrm),
    .disp     (disp),
    .baseVal  (baseVal),
    .indexVal (indexVal),
    .effAddr  (effAddr),
    .regMode  (regMode),
    .regField (regField),
    .regIsDst (regIsDst),
    .rmField  (rmField),
    .sibLen   (sibLen),
    .dispLen  (dispLen)
  );

endmodule

// File: rtl/x86EaGenChecker.sv
module x86EaGenChecker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              dirBit,
  input logic [7:0]        modrm,
  input logic              outValid,
  input logic [DATA_W-1:0] effAddr,
  input logic              regMode,
  input logic [2:0]        regField,
  input logic              regIsDst,
  input logic              sibLen,
  input logic [2:0]        dispLen
);

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && $stable(effAddr) && $stable(dispLen) && $stable(regMode)));

  assert_regmode_clean_R3: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && regMode) |-> (effAddr == '0 && !sibLen && dispLen == 3'd0));

  assert_sib_counted_R8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && modrm[7:6] != 2'd3 && modrm[2:0] == 3'd4) |=> sibLen);

  assert_fields_pass_R11: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> (regField == $past(modrm[5:3]) && regIsDst == $past(dirBit)));

  assert_disp_len_legal_R7: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (dispLen == 3'd0 || dispLen == 3'd1 || dispLen == 3'd4));

endmodule

bind x86EaGen x86EaGenChecker #(.DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_x86EaGen.sv
`timescale 1ns/1ps
module test_x86EaGen;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        dirBit = 1'b0;
  logic [7:0]  modrm = '0;
  logic [7:0]  sib = '0;
  logic [31:0] disp = '0;
  logic [2:0]  baseSel, indexSel;
  logic [31:0] baseVal, indexVal;
  logic        outValid, regMode, regIsDst, sibLen;
  logic [31:0] effAddr;
  logic [2:0]  regField, rmField, dispLen;

  logic [31:0] rf [8];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  assign baseVal  = rf[baseSel];
  assign indexVal = rf[indexSel];

  x86EaGen i_x86EaGen (
    .clk(clk), .rstN(rstN), .inValid(inValid), .dirBit(dirBit),
    .modrm(modrm), .sib(sib), .disp(disp),
    .baseSel(baseSel), .baseVal(baseVal),
    .indexSel(indexSel), .indexVal(indexVal),
    .outValid(outValid), .effAddr(effAddr), .regMode(regMode),
    .regField(regField), .regIsDst(regIsDst), .rmField(rmField),
    .sibLen(sibLen), .dispLen(dispLen)
  );

  function automatic logic [63:0] packOut();
    return 64'({effAddr, regMode, regField, regIsDst, rmField, sibLen, dispLen});
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] model(logic d, logic [7:0] m, logic [7:0] s, logic [31:0] dv);
    logic [1:0]  md = m[7:6];
    logic [2:0]  rm = m[2:0];
    logic        sibU, noBase;
    logic [31:0] ea, bTerm, iTerm, dTerm;
    logic [2:0]  dl;
    if (md == 2'd3)
      return 64'({32'h0, 1'b1, m[5:3], d, rm, 1'b0, 3'd0});
    sibU   = (rm == 3'd4);
    noBase = (md == 2'd0) && (sibU ? (s[2:0] == 3'd5) : (rm == 3'd5));
    bTerm  = noBase ? 32'h0 : rf[sibU ? s[2:0] : rm];
    iTerm  = (sibU && s[5:3] != 3'd4) ? (rf[s[5:3]] << s[7:6]) : 32'h0;
    if (md == 2'd1)      begin dTerm = {{24{dv[7]}}, dv[7:0]}; dl = 3'd1; end
    else if (md == 2'd2) begin dTerm = dv; dl = 3'd4; end
    else if (noBase)     begin dTerm = dv; dl = 3'd4; end
    else                 begin dTerm = 32'h0; dl = 3'd0; end
    ea = bTerm + iTerm + dTerm;
    return 64'({ea, 1'b0, m[5:3], d, rm, sibU, dl});
  endfunction

  function automatic string tagOf(logic [7:0] m, logic [7:0] s);
    if (m[7:6] == 2'd3) return "R3";
    if (m[2:0] == 3'd4) begin
      if (s[5:3] == 3'd4) return "R9";
      if (m[7:6] == 2'd0 && s[2:0] == 3'd5) return "R10";
      return "R8";
    end
    if (m[7:6] == 2'd1) return "R6";
    if (m[7:6] == 2'd2) return "R7";
    if (m[2:0] == 3'd5) return "R5";
    return "R4";
  endfunction

  task automatic apply(logic d, logic [7:0] m, logic [7:0] s, logic [31:0] dv, string tag);
    logic [63:0] exp;
    @(negedge clk);
    dirBit = d; modrm = m; sib = s; disp = dv; inValid = 1'b1;
    exp = model(d, m, s, dv);
    @(negedge clk);
    inValid = 1'b0;
    check(tag, packOut(), exp);
    check("R2 outValid after request", 64'(outValid), 64'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] held;
    for (int i = 0; i < 8; i++) rf[i] = 32'h0100_0000 * (i + 1) + 32'h0000_0123 * i;
    rf[3] = 32'hFFFF_FFF0;
    repeat (3) @(negedge clk);
    check("R1 reset state", {7'd0, outValid, packOut()[55:0]}, 64'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 idle after reset", {7'd0, outValid, packOut()[55:0]}, 64'd0);

    for (int m = 0; m < 256; m++) begin
      if (m[7:6] != 2'd3 && m[2:0] == 3'd4) begin
        for (int s = 0; s < 256; s++)
          apply(m[0] ^ s[1], 8'(m), 8'(s), 32'(m * 256 + s) * 32'h9E37_79B1 ^ 32'h5A5A_0F0F,
                tagOf(8'(m), 8'(s)));
      end else begin
        apply(m[1], 8'(m), 8'h00, 32'(m) * 32'h9E37_79B1 ^ 32'hA5A5_F0F0, tagOf(8'(m), 8'h00));
      end
    end

    // R12: base 0xFFFFFFF0 plus byte displacement 0x20 wraps to 0x10
    apply(1'b0, 8'b01_000_011, 8'h00, 32'h0000_0020, "R12");
    check("R12 wrapped address", 64'(effAddr), 64'h10);

    // R11: direction bit and REG field pass through
    apply(1'b1, 8'b11_101_010, 8'h00, 32'h0, "R11");
    check("R11 regIsDst/regField", 64'({regIsDst, regField}), 64'({1'b1, 3'd5}));

    // R2: inputs change with inValid low; outputs must hold
    apply(1'b0, 8'b10_010_110, 8'h00, 32'h0000_1234, "R2");
    held = packOut();
    dirBit = 1'b1; modrm = 8'b00_111_100; sib = 8'hC8; disp = 32'hDEAD_BEEF;
    @(negedge clk);
    check("R2 hold one cycle", packOut(), held);
    check("R2 outValid low when idle", 64'(outValid), 64'd0);
    repeat (4) @(negedge clk);
    check("R2 hold several cycles", packOut(), held);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule